// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of single-word transmit descriptors held in host memory. It reads the descriptor at the current ring pointer and tests the ownership flag. If the engine owns the descriptor, it passes the descriptor's control field to the transmit datapath and waits for the frame-done handshake. It then writes the status word back with the ownership flag cleared and moves to the next descriptor. If the host still owns the descriptor, the engine parks in a suspended state. It leaves that state on a poll-demand strobe or when a programmable auto-poll interval runs out, and it then reads the same descriptor again.

Software controls the engine with a run bit. Three sticky status flags report events: frame completed, engine stopped and no buffer available. Each flag is cleared by writing 1 to it. The descriptor word layout is fixed:

- bit 31: ownership (1 = engine owns the descriptor).
- bit 30: end-of-ring.
- bits 29:16: preserved by the engine.
- bits 15:0: frame control on fetch, replaced by the frame status on write-back.

Top module: `txring_engine`

## Requirements
- R1: When the fetched descriptor has bit 31 clear and run is high, the engine goes from CHECK_OWN to SUSPENDED. Status bit 2 (no buffer) reads 1 from the next cycle.
- R2: In SUSPENDED with run high, a one-cycle poll-demand pulse moves the engine to FETCH on the next cycle with the same descriptor address.
- R3: With an auto-poll interval N > 0, the engine stays in SUSPENDED for exactly N cycles and then enters FETCH. The count restarts on every entry to SUSPENDED. With N = 0 the engine stays suspended until a poll or a halt.
- R4: Run low is acted on in CHECK_OWN and in SUSPENDED. The engine goes to STOPPED and status bit 1 (stopped) reads 1 from the next cycle. A frame already in WAIT_TX or WRITEBACK finishes its write-back first.
- R5: Status bit 0 (frame done) is set only in the cycle after the write-back request is acknowledged, never earlier.
- R6: The write-back word has these fields:
  - bit 31: 0.
  - bit 30 and bits 29:16: as fetched.
  - bits 15:0: the frame status captured with frame-done.
- R7: After each write-back the address advances by STRIDE bytes, or returns to the ring base if bit 30 was set. Leaving STOPPED loads the ring base. FETCH follows the write-back directly.
- R8: In WAIT_TX, tx_req stays high until tx_done, and tx_ctl carries bits 15:0 of the fetched descriptor. The frame-done handshake moves the engine to WRITEBACK.
- R9: Each status bit is sticky and is cleared by writing 1 to its bit of sts_w1c. A set event in the same cycle wins over a clear, and a bit that is not cleared keeps its value.
- R10: eng_state encoding: STOPPED=0, FETCH=1, CHECK_OWN=2, WAIT_TX=3, WRITEBACK=4, SUSPENDED=5. After reset the engine is STOPPED with all status bits 0 and no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Start (1) / halt (0) control |
| poll_dmd | input | 1 | Poll-demand strobe |
| poll_interval | input | TW | Auto-poll interval in cycles, 0 disables |
| ring_base | input | AW | Address of the first ring entry |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Descriptor address |
| mem_wdata | output | DW | Write-back word |
| mem_rdata | input | DW | Fetched descriptor word |
| mem_ack | input | 1 | Request accepted/completed this cycle |
| tx_req | output | 1 | Frame handed to datapath |
| tx_ctl | output | STAT_W | Descriptor control field for the datapath |
| tx_done | input | 1 | Frame fully sent |
| tx_stat | input | STAT_W | Frame status, sampled with tx_done |
| sts_o | output | 3 | Sticky status {no-buffer, stopped, done} |
| sts_w1c | input | 3 | Write-1-to-clear strobes for sts_o |
| eng_state | output | 3 | Current engine state |

## Verification
Every state change and every status flag appears one clock after the input or handshake that causes it. The request, address, tx_req and tx_ctl outputs follow from the registered state and pointer, so they are valid in the cycle after that state is entered. The bench steps the clock one edge at a time. It computes the memory and datapath responses from the outputs it sees before the edge and runs a behavioural model across that same edge. Every output is compared 1 ns after the edge against the model. Directed checks also measure the SUSPENDED dwell, the tx_req hold length and the written-back words after each phase.

// File: rtl/txring_pkg.sv
package txring_pkg;
   typedef enum logic [2:0] {
      ST_STOPPED   = 3'd0,
      ST_FETCH     = 3'd1,
      ST_CHECK_OWN = 3'd2,
      ST_WAIT_TX   = 3'd3,
      ST_WRITEBACK = 3'd4,
      ST_SUSPENDED = 3'd5
   } eng_state_t;

   localparam int SB_DONE  = 0;
   localparam int SB_HALT  = 1;
   localparam int SB_NOBUF = 2;
   localparam int SB_W     = 3;
endpackage

// File: rtl/txring_poll_timer.sv
module txring_poll_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [TW-1:0] interval,
   output logic          expire
);
   localparam logic [TW-1:0] ONE = TW'(1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active)
         cnt_q <= interval;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign expire = active && (cnt_q == ONE);

   AST_TMR_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_q == '0) |=> !expire); // R3
endmodule

// File: rtl/txring_status.sv
module txring_status #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] sts_o
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sts_o[b] <= 1'b0;
         else if (set_i[b])
            sts_o[b] <= 1'b1;
         else if (clr_i[b])
            sts_o[b] <= 1'b0;
      end

      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_o[b] && !clr_i[b]) |=> sts_o[b]); // R9
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> sts_o[b]); // R9
   end
endmodule

// File: rtl/txring_ptr.sv
module txring_ptr #(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_base,
   input  logic          advance,
   input  logic          wrap,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] STEP = AW'(STRIDE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_o <= '0;
      else if (load_base)
         ptr_o <= base;
      else if (advance)
         ptr_o <= wrap ? base : ptr_o + STEP;
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_base && !advance) |=> $stable(ptr_o)); // R2
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txring_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int TW        = 16,
   parameter int STAT_W    = 16,
   parameter int STRIDE    = 16,
   parameter bit AUTO_POLL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              poll_dmd,
   input  logic [TW-1:0]     poll_interval,
   input  logic [AW-1:0]     ring_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ack,
   output logic              tx_req,
   output logic [STAT_W-1:0] tx_ctl,
   input  logic              tx_done,
   input  logic [STAT_W-1:0] tx_stat,
   output logic [SB_W-1:0]   sts_o,
   input  logic [SB_W-1:0]   sts_w1c,
   output logic [2:0]        eng_state
);
   localparam int OWN_BIT = DW - 1;
   localparam int EOR_BIT = DW - 2;

   if (STAT_W + 2 > DW) begin : g_bad_width
      $error("txring_engine: STAT_W leaves no room for flag bits");
   end
   if (STRIDE <= 0) begin : g_bad_stride
      $error("txring_engine: STRIDE must be positive");
   end
   if (TW < 1 || AW < 1) begin : g_bad_size
      $error("txring_engine: TW and AW must be at least 1");
   end

   eng_state_t           state_q, state_d;
   logic [DW-1:0]        desc_q;
   logic [STAT_W-1:0]    stat_q;
   logic [SB_W-1:0]      sts_set;
   logic                 poll_expire;
   logic                 load_base, advance;

   // next-state and status events
   always_comb begin
      state_d = state_q;
      sts_set = '0;
      unique case (state_q)
         ST_STOPPED:
            if (run_en) state_d = ST_FETCH;
         ST_FETCH:
            if (mem_ack) state_d = ST_CHECK_OWN;
         ST_CHECK_OWN:
            if (!run_en) begin
               state_d          = ST_STOPPED;
               sts_set[SB_HALT] = 1'b1;
            end else if (!desc_q[OWN_BIT]) begin
               state_d           = ST_SUSPENDED;
               sts_set[SB_NOBUF] = 1'b1;
            end else begin
               state_d = ST_WAIT_TX;
            end
         ST_WAIT_TX:
            if (tx_done) state_d = ST_WRITEBACK;
         ST_WRITEBACK:
            if (mem_ack) begin
               state_d          = ST_FETCH;
               sts_set[SB_DONE] = 1'b1;
            end
         ST_SUSPENDED:
            if (!run_en) begin
               state_d          = ST_STOPPED;
               sts_set[SB_HALT] = 1'b1;
            end else if (poll_dmd || poll_expire) begin
               state_d = ST_FETCH;
            end
         default:
            state_d = ST_STOPPED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_STOPPED;
      else
         state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_q <= '0;
         stat_q <= '0;
      end else begin
         if (state_q == ST_FETCH && mem_ack)
            desc_q <= mem_rdata;
         if (state_q == ST_WAIT_TX && tx_done)
            stat_q <= tx_stat;
      end
   end

   assign load_base = (state_q == ST_STOPPED) && run_en;
   assign advance   = (state_q == ST_WRITEBACK) && mem_ack;

   txring_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_base (load_base),
      .advance   (advance),
      .wrap      (desc_q[EOR_BIT]),
      .base      (ring_base),
      .ptr_o     (mem_addr)
   );

   if (AUTO_POLL) begin : g_autopoll
      txring_poll_timer #(.TW(TW)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (state_q == ST_SUSPENDED),
         .interval (poll_interval),
         .expire   (poll_expire)
      );
   end else begin : g_no_autopoll
      assign poll_expire = 1'b0;
   end

   txring_status #(.N(SB_W)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sts_set),
      .clr_i (sts_w1c),
      .sts_o (sts_o)
   );

   assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_WRITEBACK);
   assign mem_we    = (state_q == ST_WRITEBACK);
   assign mem_wdata = {1'b0, desc_q[EOR_BIT:STAT_W], stat_q};
   assign tx_req    = (state_q == ST_WAIT_TX);
   assign tx_ctl    = desc_q[STAT_W-1:0];
   assign eng_state = state_q;

   AST_NOBUF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK_OWN && run_en && !desc_q[OWN_BIT])
      |=> (state_q == ST_SUSPENDED && sts_o[SB_NOBUF])); // R1
   AST_RESUME_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSPENDED && run_en && poll_dmd)
      |=> (state_q == ST_FETCH && $stable(mem_addr))); // R2
   AST_HALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSPENDED && !run_en)
      |=> (state_q == ST_STOPPED && sts_o[SB_HALT])); // R4
   AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_o[SB_DONE]) |-> $past(state_q == ST_WRITEBACK && mem_ack)); // R5
   AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITEBACK && mem_ack) |=> (state_q == ST_FETCH && mem_req)); // R7
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_TX && !tx_done) |=> (tx_req && $stable(tx_ctl))); // R8
endmodule

// File: tb/txring_engine_test.sv
module txring_engine_test;
   localparam logic [31:0] BASE = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        poll_dmd = 1'b0;
   logic [15:0] poll_interval = '0;
   logic [31:0] ring_base = BASE;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        tx_req;
   logic [15:0] tx_ctl;
   logic        tx_done = 1'b0;
   logic [15:0] tx_stat = '0;
   logic [2:0]  sts_o;
   logic [2:0]  sts_w1c = '0;
   logic [2:0]  eng_state;

   txring_engine uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_dmd(poll_dmd),
      .poll_interval(poll_interval), .ring_base(ring_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .tx_req(tx_req), .tx_ctl(tx_ctl), .tx_done(tx_done), .tx_stat(tx_stat),
      .sts_o(sts_o), .sts_w1c(sts_w1c), .eng_state(eng_state)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 20000)", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // bench memory and responders
   logic [31:0] mem [0:7];
   int mlat = 0, tlat = 2, rc = 0, tc = 0;

   // reference model
   int          m_st = 0;
   logic [31:0] m_ptr = '0, m_desc = '0;
   logic [15:0] m_stat = '0;
   logic [2:0]  m_sts = '0;
   int          m_cnt = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic model_step(logic ack, logic [31:0] rd, logic done, logic [15:0] st);
      logic [2:0] s;
      s = '0;
      case (m_st)
         0: if (run_en) begin m_st = 1; m_ptr = ring_base; end
         1: if (ack) begin m_desc = rd; m_st = 2; end
         2: if (!run_en) begin m_st = 0; s[1] = 1'b1; end
            else if (!m_desc[31]) begin m_st = 5; s[2] = 1'b1; m_cnt = int'(poll_interval); end
            else m_st = 3;
         3: if (done) begin m_stat = st; m_st = 4; end
         4: if (ack) begin
               s[0] = 1'b1;
               m_ptr = m_desc[30] ? ring_base : m_ptr + 32'd16;
               m_st = 1;
            end
         5: if (!run_en) begin m_st = 0; s[1] = 1'b1; end
            else if (poll_dmd || m_cnt == 1) m_st = 1;
            else if (m_cnt != 0) m_cnt--;
         default: m_st = 0;
      endcase
      m_sts = (m_sts & ~sts_w1c) | s;
   endtask

   task automatic step();
      logic ack, done, req_b, tx_b;
      logic [2:0] idx;
      logic [15:0] st;
      idx   = 3'((mem_addr - BASE) >> 4);
      req_b = mem_req;
      tx_b  = tx_req;
      ack   = mem_req && (rc >= mlat);
      done  = tx_req && (tc >= tlat);
      st    = {8'hA5, 5'b0, idx};
      mem_ack   = ack;
      mem_rdata = mem[idx];
      tx_done   = done;
      tx_stat   = st;
      if (ack && mem_we) mem[idx] = mem_wdata;
      model_step(ack, mem[idx], done, st);
      @(posedge clk);
      #1;
      if (ack) rc = 0; else if (req_b) rc++;
      if (done) tc = 0; else if (tx_b) tc++;
      chk("R10 state", 32'(eng_state), 32'(m_st));
      chk("R5 done flag", 32'(sts_o[0]), 32'(m_sts[0]));
      chk("R4 stopped flag", 32'(sts_o[1]), 32'(m_sts[1]));
      chk("R1 nobuf flag", 32'(sts_o[2]), 32'(m_sts[2]));
      chk("R7 mem_req", 32'(mem_req), 32'(m_st == 1 || m_st == 4));
      chk("R7 mem_we", 32'(mem_we), 32'(m_st == 4));
      chk("R8 tx_req", 32'(tx_req), 32'(m_st == 3));
      if (mem_req) chk("R7 address", mem_addr, m_ptr);
      if (mem_we) chk("R6 writeback word", mem_wdata, {1'b0, m_desc[30:16], m_stat});
      if (tx_req) chk("R8 tx_ctl", 32'(tx_ctl), 32'(m_desc[15:0]));
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      int run_len, susp_len, seen_set;
      logic got;
      for (int i = 0; i < 8; i++) mem[i] = '0;
      mem[0] = 32'h8123_00C1;
      mem[1] = 32'h8456_00C2;
      mem[2] = 32'hC789_00C3;

      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset state", 32'(eng_state), 32'd0);
      chk("R10 reset status", 32'(sts_o), 32'd0);
      chk("R10 reset no request", 32'({mem_req, tx_req}), 32'd0);
      rst_n = 1'b1;

      // Phase A: three frames, wrap, suspend on the now host-owned entry
      run_en = 1'b1;
      run_len = 0; got = 1'b0;
      for (int i = 0; i < 40; i++) begin
         step();
         if (tx_req) run_len++;
         else if (run_len != 0 && !got) begin
            chk("R8 tx_req hold length", 32'(run_len), 32'(tlat + 1));
            got = 1'b1;
         end
      end
      chk("R6 own cleared", 32'(mem[0][31]), 32'd0);
      chk("R6 upper bits kept", 32'(mem[2][30:16]), 32'h4789);
      chk("R6 status field", 32'(mem[1][15:0]), 32'hA501);
      chk("R1 suspended", 32'(eng_state), 32'd5);
      chk("R5 R1 status", 32'(sts_o), 32'b101);
      chk("R7 wrapped to base", mem_addr, BASE);
      chk("R3 zero interval stays", 32'(eng_state), 32'd5);

      // Phase B: clear only the done flag
      sts_w1c = 3'b001; step();
      sts_w1c = 3'b000; step();
      chk("R9 single-bit clear", 32'(sts_o), 32'b100);

      // Phase C: poll with entry still host owned, then auto-poll
      poll_interval = 16'd5;
      poll_dmd = 1'b1; step(); poll_dmd = 1'b0;
      chk("R2 poll to fetch", 32'(eng_state), 32'd1);
      chk("R2 same address", mem_addr, BASE);
      susp_len = 0; got = 1'b0;
      for (int i = 0; i < 30; i++) begin
         step();
         if (eng_state == 3'd5) susp_len++;
         else if (eng_state == 3'd1 && susp_len != 0 && !got) begin
            chk("R3 auto-poll dwell", 32'(susp_len), 32'd5);
            got = 1'b1;
         end
      end
      mem[0] = 32'h8123_00D0;
      steps(30);
      chk("R3 frame taken after auto-poll", 32'(mem[0][15:0]), 32'hA500);

      // Phase D: halt while a frame is in flight
      mem[1] = 32'h8456_00D1;
      mem[2] = 32'hC789_00D2;
      for (int i = 0; i < 30 && eng_state != 3'd3; i++) step();
      run_en = 1'b0;
      steps(20);
      chk("R4 stopped after frame", 32'(eng_state), 32'd0);
      chk("R4 stopped flag", 32'(sts_o[1]), 32'd1);
      chk("R4 in-flight frame written back", 32'(mem[1][31]), 32'd0);

      // Phase E: restart with clears held, set must win
      mlat = 2;
      mem[0] = 32'h8123_00E0;
      sts_w1c = 3'b111;
      run_en = 1'b1;
      seen_set = 0;
      for (int i = 0; i < 30; i++) begin
         step();
         if (sts_o[0]) seen_set++;
      end
      chk("R9 set wins over clear", 32'(seen_set > 0), 32'd1);
      sts_w1c = 3'b000;
      steps(5);
      run_en = 1'b0;
      step();
      chk("R4 halt from suspended", 32'(eng_state), 32'd0);
      chk("R4 stopped flag again", 32'(sts_o[1]), 32'd1);
      steps(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule